// File: doc/BRIEF.md
# Burst-of-Two Quad-Rate SRAM Core

This block is an on-chip memory with a quad-data-rate style front end. One shared address bus carries two kinds of command: read commands, marked by an active-low read strobe, and write commands, marked by an active-low write strobe. The write-data bus and the read-data bus are separate and one-way, so a read burst and a write burst can be in flight in the same cycles. Every access moves a fixed burst of two words. The address names a two-word line, and the burst covers the whole line: beat 0 is word 0 of the line and beat 1 is word 1.

Double-rate timing is modelled on a single fast clock. An internal phase bit alternates on every edge, and each edge stands for one half of the external clock. Phase 0 edges sample read commands and phase 1 edges sample write commands. Write data follows its command over the next two edges. The write is committed to the array one edge after its second beat arrives, so the data is held in write registers for a short time first.

A read that overlaps a pending write gets the pending data, merged per 9-bit byte lane under the write mask. A read therefore always sees the newest contents. Read data leaves through an output register, and a valid flag marks both beats.

Top module: `qdrb2_sram`

The block uses two small state machines:
- The write path has the states `WR_IDLE`, `WR_BEAT0` (command taken, waiting for beat 0) and `WR_BEAT1` (beat 0 held, waiting for beat 1). Its transitions are:
  - IDLE→BEAT0 on a write command.
  - BEAT0→BEAT1 always.
  - BEAT1→BEAT0 on a back-to-back write command.
  - BEAT1→IDLE otherwise.
- The read path has the states `RD_IDLE`, `RD_BEAT0` (fetching beat 0) and `RD_BEAT1` (fetching beat 1). Its transitions are:
  - IDLE→BEAT0 on a read command.
  - BEAT0→BEAT1 always.
  - BEAT1→BEAT0 on a back-to-back read command.
  - BEAT1→IDLE otherwise.

## Requirements
- R1: While `rst` is high, `rd_valid` is 0, `rd_data` is 0 and `phase` is 0.
- R2: After reset, `phase` toggles on every clock edge, and the first edge after reset is a phase 0 edge. A command is sampled at an edge whose pre-edge `phase` value selects it: 0 selects a read and 1 selects a write.
- R3: A read command (`rd_n`=0 at a phase 0 edge E) presents beat 0 on `rd_data` after edge E+1 and beat 1 after edge E+2. `rd_valid` is 1 in both of those cycles.
- R4: A write command (`wr_n`=0 at a phase 1 edge W) takes beat 0 from `wr_data`/`bw_n` at edge W+1 and beat 1 at edge W+2. Line `addr` holds two words: beat 0 is word 0 and beat 1 is word 1.
- R5: `bw_n[i]`=0 writes bits [9i+8:9i] of the beat. `bw_n[i]`=1 leaves that lane's old contents in place. Each beat has its own mask.
- R6: A read command at edge W+1 to the line written by a command at edge W returns the new data for both beats, merged per lane with the old contents.
- R7: Read commands and write commands to different lines may be issued in every phase 0 and every phase 1 edge respectively, with no gaps, and all of them complete correctly.
- R8: When no read burst is being output, `rd_valid` is 0 and `rd_data` keeps its last value.
- R9: A low `rd_n` at a phase 1 edge has no effect, and a low `wr_n` at a phase 0 edge has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast clock; each edge is one half of the modelled external clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_n | input | 1 | Active-low read strobe, sampled on phase 0 edges |
| wr_n | input | 1 | Active-low write strobe, sampled on phase 1 edges |
| addr | input | ADDR_W | Shared line address for read and write commands |
| wr_data | input | LANES*LANE_W | Write data beat |
| bw_n | input | LANES | Active-low per-lane write enables for the current beat |
| rd_data | output | LANES*LANE_W | Registered read data beat |
| rd_valid | output | 1 | High while `rd_data` carries a read beat |
| phase | output | 1 | Current half-clock phase; tells the host which command the next edge samples |

## Verification
The assertions assume the following about the host:
- Strobes and the address change only between edges.
- Write data and masks for a burst are presented in exactly the two cycles after its command.
- A line is read only after it has been written, because the array is not cleared at reset.

The bench drives every input on the falling edge, and it aligns each command to the `phase` output before asserting a strobe. Before any read, it fills every line it will later read with full-mask writes. Off-phase strobes are driven only in the directed test that checks they are ignored.

// File: rtl/qdrb2_pkg.sv
package qdrb2_pkg;

    typedef enum logic [1:0] {
        WR_IDLE  = 2'd0,
        WR_BEAT0 = 2'd1,
        WR_BEAT1 = 2'd2
    } wr_state_e;

    typedef enum logic [1:0] {
        RD_IDLE  = 2'd0,
        RD_BEAT0 = 2'd1,
        RD_BEAT1 = 2'd2
    } rd_state_e;

endpackage

// File: rtl/qdrb2_wr_path.sv
module qdrb2_wr_path
    import qdrb2_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 9,
    localparam int WORD_W = LANES * LANE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              phase,
    input  logic              wr_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [LANES-1:0]  bw_n,
    output logic              cap_v,
    output logic [ADDR_W-1:0] cap_addr,
    output logic [WORD_W-1:0] cap_d0,
    output logic [LANES-1:0]  cap_bw0_n,
    output logic              com_v,
    output logic [ADDR_W-1:0] com_addr,
    output logic [WORD_W-1:0] com_d0,
    output logic [WORD_W-1:0] com_d1,
    output logic [LANES-1:0]  com_bw0_n,
    output logic [LANES-1:0]  com_bw1_n
);

    wr_state_e         state, state_nx;
    logic              take_cmd;
    logic [ADDR_W-1:0] cmd_addr;

    assign take_cmd = phase && !wr_n;

    always_ff @(posedge clk) begin
        if (rst) state <= WR_IDLE;
        else     state <= state_nx;
    end

    always_comb begin
        unique case (state)
            WR_IDLE:  state_nx = take_cmd ? WR_BEAT0 : WR_IDLE;
            WR_BEAT0: state_nx = WR_BEAT1;
            WR_BEAT1: state_nx = take_cmd ? WR_BEAT0 : WR_IDLE;
            default:  state_nx = WR_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_addr  <= '0;
            cap_d0    <= '0;
            cap_bw0_n <= '1;
            com_v     <= 1'b0;
            com_addr  <= '0;
            com_d0    <= '0;
            com_d1    <= '0;
            com_bw0_n <= '1;
            com_bw1_n <= '1;
        end else begin
            if (take_cmd) cmd_addr <= addr;
            if (state == WR_BEAT0) begin
                cap_d0    <= wr_data;
                cap_bw0_n <= bw_n;
            end
            com_v <= (state == WR_BEAT1);
            if (state == WR_BEAT1) begin
                com_addr  <= cmd_addr;
                com_d0    <= cap_d0;
                com_d1    <= wr_data;
                com_bw0_n <= cap_bw0_n;
                com_bw1_n <= bw_n;
            end
        end
    end

    assign cap_v    = (state == WR_BEAT1);
    assign cap_addr = cmd_addr;

    // R4
    wr_seq_chk: assert property (@(posedge clk) disable iff (rst)
        (state == WR_BEAT0) |=> (state == WR_BEAT1));

    // R4
    commit_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        com_v |=> !com_v);

    // R9
    wr_offphase_chk: assert property (@(posedge clk) disable iff (rst)
        (state == WR_IDLE && !phase) |=> (state == WR_IDLE));

    // R6
    fwd_src_excl_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({cap_v, com_v}));

endmodule

// File: rtl/qdrb2_array.sv
module qdrb2_array #(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 9,
    localparam int WORD_W = LANES * LANE_W,
    localparam int LINES  = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [WORD_W-1:0] wd0,
    input  logic [WORD_W-1:0] wd1,
    input  logic [LANES-1:0]  wbw0_n,
    input  logic [LANES-1:0]  wbw1_n,
    input  logic [ADDR_W-1:0] raddr,
    output logic [WORD_W-1:0] rd0,
    output logic [WORD_W-1:0] rd1
);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] bank0 [LINES];
        logic [LANE_W-1:0] bank1 [LINES];

        always_ff @(posedge clk) begin
            if (we && !wbw0_n[g]) bank0[waddr] <= wd0[g*LANE_W +: LANE_W];
            if (we && !wbw1_n[g]) bank1[waddr] <= wd1[g*LANE_W +: LANE_W];
        end

        assign rd0[g*LANE_W +: LANE_W] = bank0[raddr];
        assign rd1[g*LANE_W +: LANE_W] = bank1[raddr];
    end

endmodule

// File: rtl/qdrb2_rd_path.sv
module qdrb2_rd_path
    import qdrb2_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 9,
    localparam int WORD_W = LANES * LANE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              phase,
    input  logic              rd_n,
    input  logic [ADDR_W-1:0] addr,
    output logic [ADDR_W-1:0] raddr,
    input  logic [WORD_W-1:0] arr_d0,
    input  logic [WORD_W-1:0] arr_d1,
    input  logic              cap_v,
    input  logic [ADDR_W-1:0] cap_addr,
    input  logic [WORD_W-1:0] cap_d0,
    input  logic [LANES-1:0]  cap_bw0_n,
    input  logic              com_v,
    input  logic [ADDR_W-1:0] com_addr,
    input  logic [WORD_W-1:0] com_d0,
    input  logic [WORD_W-1:0] com_d1,
    input  logic [LANES-1:0]  com_bw0_n,
    input  logic [LANES-1:0]  com_bw1_n,
    output logic [WORD_W-1:0] rd_data,
    output logic              rd_valid
);

    rd_state_e         state, state_nx;
    logic              take_cmd;
    logic              second;
    logic              hit_cap, hit_com;
    logic [WORD_W-1:0] base, com_d, merged;
    logic [LANES-1:0]  com_m;

    assign take_cmd = !phase && !rd_n;

    always_ff @(posedge clk) begin
        if (rst) state <= RD_IDLE;
        else     state <= state_nx;
    end

    always_comb begin
        unique case (state)
            RD_IDLE:  state_nx = take_cmd ? RD_BEAT0 : RD_IDLE;
            RD_BEAT0: state_nx = RD_BEAT1;
            RD_BEAT1: state_nx = take_cmd ? RD_BEAT0 : RD_IDLE;
            default:  state_nx = RD_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)           raddr <= '0;
        else if (take_cmd) raddr <= addr;
    end

    // Newest source wins per lane: held beat 0, then commit register, then array
    assign second  = (state == RD_BEAT1);
    assign base    = second ? arr_d1 : arr_d0;
    assign com_d   = second ? com_d1 : com_d0;
    assign com_m   = second ? com_bw1_n : com_bw0_n;
    assign hit_com = com_v && (com_addr == raddr);
    assign hit_cap = cap_v && (cap_addr == raddr) && !second;

    for (genvar g = 0; g < LANES; g++) begin : g_merge
        assign merged[g*LANE_W +: LANE_W] =
            (hit_cap && !cap_bw0_n[g]) ? cap_d0[g*LANE_W +: LANE_W] :
            (hit_com && !com_m[g])     ? com_d[g*LANE_W +: LANE_W]  :
                                         base[g*LANE_W +: LANE_W];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= (state != RD_IDLE);
            if (state != RD_IDLE) rd_data <= merged;
        end
    end

    // R3
    rd_cmd_valid_chk: assert property (@(posedge clk) disable iff (rst)
        (!phase && !rd_n) |=> ##1 rd_valid);

    // R3
    rd_pair_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(rd_valid) |=> rd_valid);

    // R8
    rd_idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !rd_valid |-> $stable(rd_data));

    // R9
    rd_offphase_chk: assert property (@(posedge clk) disable iff (rst)
        (state == RD_IDLE && phase) |=> (state == RD_IDLE));

endmodule

// File: rtl/qdrb2_sram.sv
module qdrb2_sram #(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 9,
    localparam int WORD_W = LANES * LANE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_n,
    input  logic              wr_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [LANES-1:0]  bw_n,
    output logic [WORD_W-1:0] rd_data,
    output logic              rd_valid,
    output logic              phase
);

    logic              cap_v, com_v;
    logic [ADDR_W-1:0] cap_addr, com_addr, raddr;
    logic [WORD_W-1:0] cap_d0, com_d0, com_d1, arr_d0, arr_d1;
    logic [LANES-1:0]  cap_bw0_n, com_bw0_n, com_bw1_n;

    always_ff @(posedge clk) begin
        if (rst) phase <= 1'b0;
        else     phase <= ~phase;
    end

    // R2
    phase_toggle_chk: assert property (@(posedge clk) disable iff (rst)
        !rst |=> (phase != $past(phase)));

    qdrb2_wr_path #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_wr (
        .clk(clk), .rst(rst), .phase(phase), .wr_n(wr_n), .addr(addr),
        .wr_data(wr_data), .bw_n(bw_n),
        .cap_v(cap_v), .cap_addr(cap_addr), .cap_d0(cap_d0), .cap_bw0_n(cap_bw0_n),
        .com_v(com_v), .com_addr(com_addr), .com_d0(com_d0), .com_d1(com_d1),
        .com_bw0_n(com_bw0_n), .com_bw1_n(com_bw1_n)
    );

    qdrb2_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_arr (
        .clk(clk), .we(com_v), .waddr(com_addr), .wd0(com_d0), .wd1(com_d1),
        .wbw0_n(com_bw0_n), .wbw1_n(com_bw1_n), .raddr(raddr),
        .rd0(arr_d0), .rd1(arr_d1)
    );

    qdrb2_rd_path #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_rd (
        .clk(clk), .rst(rst), .phase(phase), .rd_n(rd_n), .addr(addr),
        .raddr(raddr), .arr_d0(arr_d0), .arr_d1(arr_d1),
        .cap_v(cap_v), .cap_addr(cap_addr), .cap_d0(cap_d0), .cap_bw0_n(cap_bw0_n),
        .com_v(com_v), .com_addr(com_addr), .com_d0(com_d0), .com_d1(com_d1),
        .com_bw0_n(com_bw0_n), .com_bw1_n(com_bw1_n),
        .rd_data(rd_data), .rd_valid(rd_valid)
    );

endmodule

// File: tb/qdrb2_sram_test.sv
module qdrb2_sram_test;

    localparam int AW = 6;
    localparam int NL = 4;
    localparam int LW = 9;
    localparam int DW = NL * LW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          rd_n = 1'b1;
    logic          wr_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic [NL-1:0] bw_n = '1;
    logic [DW-1:0] rd_data;
    logic          rd_valid;
    logic          phase;

    logic [DW-1:0] mdl [0:(2<<AW)-1];
    int            n_cmp = 0;
    int            n_bad = 0;

    always #5 clk = ~clk;

    qdrb2_sram #(.ADDR_W(AW), .LANES(NL), .LANE_W(LW)) uut (
        .clk(clk), .rst(rst), .rd_n(rd_n), .wr_n(wr_n), .addr(addr),
        .wr_data(wr_data), .bw_n(bw_n), .rd_data(rd_data),
        .rd_valid(rd_valid), .phase(phase)
    );

    task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] lane_mix(input logic [DW-1:0] old_w,
                                               input logic [DW-1:0] new_w,
                                               input logic [NL-1:0] m_n);
        logic [DW-1:0] r = old_w;
        for (int i = 0; i < NL; i++)
            if (!m_n[i]) r[i*LW +: LW] = new_w[i*LW +: LW];
        return r;
    endfunction

    function automatic logic [DW-1:0] pat(input int s);
        return DW'(64'h9_1357_2468 ^ (64'(s) * 64'h1_0F1E_2D3C));
    endfunction

    task automatic wait_ph(input logic p);
        do @(negedge clk); while (phase !== p);
    endtask

    task automatic wr_burst(input int a, input logic [DW-1:0] d0, input logic [DW-1:0] d1,
                            input logic [NL-1:0] m0, input logic [NL-1:0] m1);
        wait_ph(1'b1);
        wr_n = 1'b0; addr = AW'(a);
        @(negedge clk);
        wr_n = 1'b1; wr_data = d0; bw_n = m0;
        @(negedge clk);
        wr_data = d1; bw_n = m1;
        @(negedge clk);
        bw_n = '1;
        mdl[2*a]   = lane_mix(mdl[2*a], d0, m0);
        mdl[2*a+1] = lane_mix(mdl[2*a+1], d1, m1);
    endtask

    task automatic rd_burst(input int a, input string req);
        wait_ph(1'b0);
        rd_n = 1'b0; addr = AW'(a);
        @(negedge clk);
        rd_n = 1'b1;
        @(negedge clk);
        chk({req, " valid beat0"}, DW'(rd_valid), DW'(1));
        chk({req, " beat0"}, rd_data, mdl[2*a]);
        @(negedge clk);
        chk({req, " valid beat1"}, DW'(rd_valid), DW'(1));
        chk({req, " beat1"}, rd_data, mdl[2*a+1]);
    endtask

    // R1 R2: reset values and phase alternation
    task automatic t_reset();
        repeat (3) @(negedge clk);
        chk("R1 rd_valid", DW'(rd_valid), DW'(0));
        chk("R1 rd_data", rd_data, '0);
        chk("R1 phase", DW'(phase), DW'(0));
        rst = 1'b0;
        @(negedge clk);
        chk("R2 phase after edge 1", DW'(phase), DW'(1));
        @(negedge clk);
        chk("R2 phase after edge 2", DW'(phase), DW'(0));
    endtask

    // R3 R4: fill lines, read back, idle after burst
    task automatic t_fill();
        for (int a = 0; a < 8; a++) wr_burst(a, pat(2*a), pat(2*a+1), '0, '0);
        for (int a = 0; a < 8; a++) begin
            rd_burst(a, "R4");
            @(negedge clk);
            chk("R3 valid drops after beat1", DW'(rd_valid), DW'(0));
        end
    endtask

    // R5: per-lane masks, different per beat
    task automatic t_mask();
        wr_burst(3, pat(100), pat(101), 4'b1010, 4'b0111);
        rd_burst(3, "R5");
        wr_burst(4, pat(102), pat(103), 4'b1111, 4'b0000);
        rd_burst(4, "R5 beat0 masked off");
    endtask

    // R6: read issued one edge after the write command to the same line
    task automatic t_fwd(input int a, input logic [NL-1:0] m0, input logic [NL-1:0] m1, input int s);
        logic [DW-1:0] e0, e1;
        e0 = lane_mix(mdl[2*a], pat(s), m0);
        e1 = lane_mix(mdl[2*a+1], pat(s+1), m1);
        mdl[2*a] = e0; mdl[2*a+1] = e1;
        wait_ph(1'b1);
        wr_n = 1'b0; addr = AW'(a);
        @(negedge clk);
        wr_n = 1'b1; wr_data = pat(s); bw_n = m0; rd_n = 1'b0;
        @(negedge clk);
        rd_n = 1'b1; wr_data = pat(s+1); bw_n = m1;
        @(negedge clk);
        bw_n = '1;
        chk("R6 valid beat0", DW'(rd_valid), DW'(1));
        chk("R6 forwarded beat0", rd_data, e0);
        @(negedge clk);
        chk("R6 valid beat1", DW'(rd_valid), DW'(1));
        chk("R6 forwarded beat1", rd_data, e1);
        rd_burst(a, "R6 after commit");
    endtask

    // R7: gapless reads of lines 0..3 interleaved with gapless writes to 8..11
    task automatic t_stream();
        logic [DW-1:0] x0 [4];
        logic [DW-1:0] x1 [4];
        for (int i = 0; i < 4; i++) begin
            x0[i] = mdl[2*i]; x1[i] = mdl[2*i+1];
        end
        wait_ph(1'b0);
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            if (i >= 2) begin
                chk("R7 stream valid beat1", DW'(rd_valid), DW'(1));
                chk("R7 stream beat1", rd_data, x1[i-2]);
            end
            wr_n = (i < 4) ? 1'b0 : 1'b1;
            rd_n = 1'b1;
            addr = AW'(8 + i);
            wr_data = (i >= 1 && i <= 4) ? pat(201 + 2*(i-1)) : '0;
            bw_n = (i >= 1 && i <= 4) ? '0 : '1;
            @(negedge clk);
            if (i >= 1 && i <= 4) begin
                chk("R7 stream valid beat0", DW'(rd_valid), DW'(1));
                chk("R7 stream beat0", rd_data, x0[i-1]);
            end
            wr_n = 1'b1;
            rd_n = (i < 4) ? 1'b0 : 1'b1;
            addr = AW'(i);
            wr_data = (i < 4) ? pat(200 + 2*i) : '0;
            bw_n = (i < 4) ? '0 : '1;
        end
        @(negedge clk);
        rd_n = 1'b1; bw_n = '1;
        for (int i = 0; i < 4; i++) begin
            mdl[2*(8+i)] = pat(200 + 2*i);
            mdl[2*(8+i)+1] = pat(201 + 2*i);
        end
        for (int i = 0; i < 4; i++) rd_burst(8 + i, "R7 written lines");
    endtask

    // R8: output holds after a burst
    task automatic t_idle();
        rd_burst(1, "R8 setup");
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            chk("R8 valid low", DW'(rd_valid), DW'(0));
            chk("R8 data held", rd_data, mdl[3]);
        end
    endtask

    // R9: off-phase strobes are ignored
    task automatic t_ignore();
        wait_ph(1'b1);
        rd_n = 1'b0; addr = AW'(2);
        @(negedge clk);
        rd_n = 1'b1;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk("R9 read on phase1 ignored", DW'(rd_valid), DW'(0));
        end
        wait_ph(1'b0);
        wr_n = 1'b0; addr = AW'(5); wr_data = pat(999); bw_n = '0;
        @(negedge clk);
        wr_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
        bw_n = '1;
        rd_burst(5, "R9 write on phase0 ignored");
    endtask

    initial begin
        t_reset();
        t_fill();
        t_mask();
        t_fwd(6, 4'b0000, 4'b0000, 300);
        t_fwd(7, 4'b0110, 4'b1001, 310);
        t_stream();
        t_idle();
        t_ignore();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule